// File: doc/BRIEF.md
# Audio Descriptor FIFO Controller

This block is the register-mapped control side of one direction of an audio DMA channel. Software hands it buffer descriptors (a start address and a byte count) through a free-descriptor FIFO. A fetch model takes one descriptor at a time. It counts one `sample_tick` for every four bytes while the channel is enabled, then moves the finished descriptor into a completed-descriptor FIFO. Software drains that FIFO from its interrupt handler.

Both FIFO levels, three sticky flags and the interrupt line can be seen through a 32-bit register port that is addressed by word index. Each FIFO has its own threshold. The completed FIFO raises its flag once enough descriptors have finished. The free FIFO raises its flag when it runs low.

Register word indices: 0 channel control, 1 interrupt status/clear, 2 interrupt enable, 3 free-FIFO threshold, 4 completed-FIFO threshold, 5 free-FIFO address (commit), 6 free-FIFO length, 7 completed-FIFO address, 8 completed-FIFO length (pop), 9 auxiliary configuration.

Top module: `adfc_top`

## Requirements
- R1: After reset both FIFO levels read 0, the control and interrupt-enable registers read 0, both thresholds read 4, and `irq` is low.
- R2: Writing word 6 stages a length, and writing word 5 commits {staged length, address} to the free FIFO. The status register reports the free-FIFO level in bits 11:8 and the completed-FIFO level in bits 15:12.
- R3: A commit while the free FIFO is full (8 entries) is dropped, the level stays 8, and status bit 2 is set and stays set until it is cleared.
- R4: While control bit 31 is 0, no descriptor is taken and ticks are not counted.
- R5: A descriptor of length L completes after L/4 sample ticks counted while enabled; a length below 4 completes with no tick.
- R6: Completed descriptors leave in commit order, with their address and length intact.
- R7: Reading word 7 returns the head address without popping. Reading word 8 returns the head length and pops it. Both return 0 when the FIFO is empty, and the level never goes below 0.
- R8: Status bit 1 is set while the completed level is at least the completed threshold (a threshold of 0 never fires). `irq` is high when a status flag bit 0 or 1 is set and the matching enable bit is set.
- R9: Writing word 1 keeps only the flags whose write-data bit is 1, so writing 0 clears them. A flag whose condition still holds is set again on the next cycle.
- R10: When the completed FIFO is full, the finished descriptor waits, and it enters as soon as an entry is popped.
- R11: Status bit 0 is set while the free-FIFO level is at most the free-FIFO threshold.
- R12: The auxiliary configuration word reads back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_rd | input | 1 | Register read strobe, one cycle (side effect on word 8) |
| reg_word | input | 4 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of `reg_rd` |
| sample_tick | input | 1 | One pulse per 4 bytes moved by the data path |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the stall: a finished descriptor held back because the completed FIFO already holds eight entries. Zero-length descriptors reach it quickly, because they complete without ticks. The bench commits nine of them with the channel enabled. It checks that the completed level stops at 8 and the free level drops to 0. After one pop, the held entry must enter, and all eight must then drain in commit order. Overflow is reached by the opposite route: the channel is disabled, so nothing drains the free FIFO while nine commits arrive.

// File: rtl/adfc_pkg.sv
package adfc_pkg;
  localparam int DATA_W = 32;

  typedef struct packed {
    logic [DATA_W-1:0] addr;
    logic [DATA_W-1:0] len;
  } desc_t;

  localparam int DESC_W = 2 * DATA_W;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_RUN  = 2'd1,
    ENG_DONE = 2'd2
  } eng_state_e;

  localparam logic [3:0] W_CTRL   = 4'd0;
  localparam logic [3:0] W_STAT   = 4'd1;
  localparam logic [3:0] W_IEN    = 4'd2;
  localparam logic [3:0] W_FTHR   = 4'd3;
  localparam logic [3:0] W_CTHR   = 4'd4;
  localparam logic [3:0] W_FADDR  = 4'd5;
  localparam logic [3:0] W_FLEN   = 4'd6;
  localparam logic [3:0] W_CADDR  = 4'd7;
  localparam logic [3:0] W_CLEN   = 4'd8;
  localparam logic [3:0] W_AUX    = 4'd9;
endpackage

// File: rtl/adfc_desc_fifo.sv
module adfc_desc_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 64,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  output logic          accepted,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          full,
  output logic          empty,
  output logic [LW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [LW-1:0] cnt_q, cnt_n;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] adv(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == LW'(DEPTH));
  assign level    = cnt_q;
  assign dout     = mem[rp_q];
  assign accepted = do_push;

  always_comb begin
    do_pop  = pop && !empty;
    do_push = push && (!full || do_pop);
    wp_n    = do_push ? adv(wp_q) : wp_q;
    rp_n    = do_pop  ? adv(rp_q) : rp_q;
    cnt_n   = cnt_q;
    if (do_push && !do_pop)      cnt_n = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

  // R3: level never passes the depth, whatever the commit rate
  p_level_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LW'(DEPTH));

  // R7: a pop on an empty FIFO leaves it empty
  p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/adfc_fetch.sv
module adfc_fetch
  import adfc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  tick,
  input  logic  in_valid,
  input  desc_t in_desc,
  output logic  in_pop,
  input  logic  out_full,
  output logic  out_push,
  output desc_t out_desc
);
  eng_state_e        state_q, state_n;
  logic [DATA_W-1:0] cnt_q, cnt_n;
  desc_t             act_q, act_n;

  assign out_desc = act_q;

  always_comb begin
    state_n  = state_q;
    cnt_n    = cnt_q;
    act_n    = act_q;
    in_pop   = 1'b0;
    out_push = 1'b0;
    unique case (state_q)
      ENG_IDLE: if (en && in_valid) begin
        in_pop  = 1'b1;
        act_n   = in_desc;
        cnt_n   = in_desc.len >> 2;
        state_n = ENG_RUN;
      end
      ENG_RUN: begin
        if (cnt_q == '0)      state_n = ENG_DONE;
        else if (en && tick)  cnt_n   = cnt_q - 1'b1;
      end
      ENG_DONE: if (en && !out_full) begin
        out_push = 1'b1;
        state_n  = ENG_IDLE;
      end
      default: state_n = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      cnt_q   <= '0;
      act_q   <= '0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      act_q   <= act_n;
    end
  end

  // R4: nothing is counted or loaded while the channel is off
  p_hold_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt_q));

  // R5: one tick in the run state removes exactly one word
  p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ENG_RUN && en && tick && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R10: a finished descriptor waits while the completed FIFO is full
  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ENG_DONE && out_full) |=> (state_q == ENG_DONE));
endmodule

// File: rtl/adfc_top.sv
module adfc_top
  import adfc_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int THR_RESET = 4,
  localparam int LW       = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [3:0]  reg_word,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        sample_tick,
  output logic        irq
);
  logic [1:0] rsync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  logic        en_q, en_n;
  logic [31:0] aux_q, aux_n, stage_q, stage_n;
  logic [1:0]  ien_q, ien_n;
  logic [3:0]  fthr_q, fthr_n, cthr_q, cthr_n;
  logic [2:0]  flag_q, flag_n;

  desc_t         free_in, free_head, done_head, eng_out;
  logic          commit, free_acc, free_full, free_empty, eng_pop;
  logic          done_pop, done_push, done_full, done_empty, done_acc;
  logic [LW-1:0] free_lvl, done_lvl;
  logic [3:0]    free_f, done_f;
  logic          wr_ctrl, wr_stat, wr_ien, wr_fthr, wr_cthr, wr_flen, wr_aux;

  assign wr_ctrl  = reg_wr && reg_word == W_CTRL;
  assign wr_stat  = reg_wr && reg_word == W_STAT;
  assign wr_ien   = reg_wr && reg_word == W_IEN;
  assign wr_fthr  = reg_wr && reg_word == W_FTHR;
  assign wr_cthr  = reg_wr && reg_word == W_CTHR;
  assign wr_flen  = reg_wr && reg_word == W_FLEN;
  assign wr_aux   = reg_wr && reg_word == W_AUX;
  assign commit   = reg_wr && reg_word == W_FADDR;
  assign done_pop = reg_rd && reg_word == W_CLEN;
  assign free_in  = '{addr: reg_wdata, len: stage_q};
  assign free_f   = 4'(free_lvl);
  assign done_f   = 4'(done_lvl);

  adfc_desc_fifo #(.DEPTH(DEPTH), .W(DESC_W)) u_free (
    .clk(clk), .rst_n(rst_ni), .push(commit), .din(free_in), .accepted(free_acc),
    .pop(eng_pop), .dout(free_head), .full(free_full), .empty(free_empty), .level(free_lvl));

  adfc_desc_fifo #(.DEPTH(DEPTH), .W(DESC_W)) u_done (
    .clk(clk), .rst_n(rst_ni), .push(done_push), .din(eng_out), .accepted(done_acc),
    .pop(done_pop), .dout(done_head), .full(done_full), .empty(done_empty), .level(done_lvl));

  adfc_fetch u_fetch (
    .clk(clk), .rst_n(rst_ni), .en(en_q), .tick(sample_tick),
    .in_valid(!free_empty), .in_desc(free_head), .in_pop(eng_pop),
    .out_full(done_full), .out_push(done_push), .out_desc(eng_out));

  always_comb begin
    en_n    = wr_ctrl ? reg_wdata[31]   : en_q;
    aux_n   = wr_aux  ? reg_wdata       : aux_q;
    stage_n = wr_flen ? reg_wdata       : stage_q;
    ien_n   = wr_ien  ? reg_wdata[1:0]  : ien_q;
    fthr_n  = wr_fthr ? reg_wdata[3:0]  : fthr_q;
    cthr_n  = wr_cthr ? reg_wdata[3:0]  : cthr_q;
    flag_n  = wr_stat ? (flag_q & reg_wdata[2:0]) : flag_q;
    if (free_f <= fthr_q)                     flag_n[0] = 1'b1;
    if (cthr_q != 4'd0 && done_f >= cthr_q)   flag_n[1] = 1'b1;
    if (commit && !free_acc)                  flag_n[2] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      aux_q   <= '0;
      stage_q <= '0;
      ien_q   <= '0;
      fthr_q  <= 4'(THR_RESET);
      cthr_q  <= 4'(THR_RESET);
      flag_q  <= '0;
    end else begin
      en_q    <= en_n;
      aux_q   <= aux_n;
      stage_q <= stage_n;
      ien_q   <= ien_n;
      fthr_q  <= fthr_n;
      cthr_q  <= cthr_n;
      flag_q  <= flag_n;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      unique case (reg_word)
        W_CTRL:  reg_rdata = {en_q, 31'd0};
        W_STAT:  reg_rdata = {16'd0, done_f, free_f, 5'd0, flag_q};
        W_IEN:   reg_rdata = {30'd0, ien_q};
        W_FTHR:  reg_rdata = {28'd0, fthr_q};
        W_CTHR:  reg_rdata = {28'd0, cthr_q};
        W_FLEN:  reg_rdata = stage_q;
        W_CADDR: reg_rdata = done_empty ? '0 : done_head.addr;
        W_CLEN:  reg_rdata = done_empty ? '0 : done_head.len;
        W_AUX:   reg_rdata = aux_q;
        default: reg_rdata = '0;
      endcase
    end
  end

  assign irq = |(flag_q[1:0] & ien_q);

  // R3: the overflow flag survives until a clear write removes it
  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (flag_q[2] && !(wr_stat && !reg_wdata[2])) |=> flag_q[2]);

  // R3: a dropped commit never reaches the free FIFO
  p_drop_full_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (commit && free_full && !eng_pop) |=> (free_lvl == LW'(DEPTH)));

  // R10: the engine only hands over a descriptor the completed FIFO takes
  p_push_taken_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    done_push |-> done_acc);
endmodule

// File: tb/adfc_top_bench.sv
`timescale 1ns/1ps
module adfc_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, sample_tick = 1'b0;
  logic [3:0]  reg_word = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  int checks = 0, errors = 0, cyc = 0;

  always #2.5 clk = ~clk;

  adfc_top u_adfc_top (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_word(reg_word),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sample_tick(sample_tick), .irq(irq));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog expired got %0d exp below 100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] w, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_word = w; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] w, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_word = w;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tick();
    @(negedge clk); sample_tick = 1'b1;
    @(negedge clk); sample_tick = 1'b0;
  endtask

  // {is_read, word, data_or_expected, requirement}
  localparam int NV = 24;
  localparam logic [40:0] VEC [NV] = '{
    {1'b1, 4'd4, 32'h4,          4'd1},  // R1 completed threshold
    {1'b1, 4'd3, 32'h4,          4'd1},  // R1 free threshold
    {1'b1, 4'd0, 32'h0,          4'd1},  // R1 control
    {1'b1, 4'd1, 32'h1,          4'd11}, // R11 level 0 <= 4
    {1'b0, 4'd6, 32'd8,          4'd2},
    {1'b0, 4'd5, 32'h100,        4'd2},
    {1'b1, 4'd1, 32'h101,        4'd2},  // R2 free level in 11:8
    {1'b0, 4'd6, 32'd4,          4'd2},
    {1'b0, 4'd5, 32'h200,        4'd2},
    {1'b0, 4'd6, 32'd16,         4'd2},
    {1'b0, 4'd5, 32'h300,        4'd2},
    {1'b0, 4'd6, 32'd0,          4'd2},
    {1'b0, 4'd5, 32'h400,        4'd2},
    {1'b0, 4'd6, 32'd12,         4'd2},
    {1'b0, 4'd5, 32'h500,        4'd2},
    {1'b1, 4'd1, 32'h501,        4'd2},  // R2 five queued, flag sticky
    {1'b0, 4'd1, 32'h0,          4'd9},
    {1'b1, 4'd1, 32'h500,        4'd9},  // R9 cleared, 5 > 4
    {1'b1, 4'd8, 32'h0,          4'd7},  // R7 empty length
    {1'b1, 4'd7, 32'h0,          4'd7},  // R7 empty address
    {1'b1, 4'd1, 32'h500,        4'd7},  // R7 no underflow
    {1'b0, 4'd9, 32'hA5A50001,   4'd12},
    {1'b1, 4'd9, 32'hA5A50001,   4'd12}, // R12 read back
    {1'b1, 4'd2, 32'h0,          4'd1}   // R1 enable
  };

  logic [31:0] d;
  logic [31:0] exp_addr [5] = '{32'h100, 32'h200, 32'h300, 32'h400, 32'h500};
  logic [31:0] exp_len  [5] = '{32'd8, 32'd4, 32'd16, 32'd0, 32'd12};

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(5);
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][40]) begin
        rd(VEC[i][39:36], d);
        chk($sformatf("R%0d vector %0d", VEC[i][3:0], i), d, VEC[i][35:4]);
      end else begin
        wr(VEC[i][39:36], VEC[i][35:4]);
      end
    end

    // R4: ticks while disabled change nothing
    for (int i = 0; i < 6; i++) pulse_tick();
    wait_cyc(4);
    rd(4'd1, d); chk("R4 disabled no consumption", d, 32'h500);

    // R5 / R8: enable with completed threshold 1
    wr(4'd4, 32'd1);
    wr(4'd2, 32'd2);
    wr(4'd0, 32'h8000_0000);
    wait_cyc(4);
    pulse_tick();
    wait_cyc(5);
    rd(4'd1, d); chk("R5 one tick of two", {28'd0, d[15:12]}, 32'd0);
    chk("R8 irq low before completion", {31'd0, irq}, 32'd0);
    pulse_tick();
    wait_cyc(5);
    rd(4'd1, d); chk("R5 completes after L/4 ticks", {28'd0, d[15:12]}, 32'd1);
    chk("R8 status bit 1", {31'd0, d[1]}, 32'd1);
    chk("R8 irq high", {31'd0, irq}, 32'd1);
    for (int i = 0; i < 8; i++) begin
      pulse_tick();
      wait_cyc(7);
    end
    wait_cyc(6);
    rd(4'd1, d); chk("R5 all completed", {24'd0, d[15:8]}, 32'h50);

    // R6 / R7: drain in order
    rd(4'd7, d); chk("R7 address peek", d, 32'h100);
    rd(4'd7, d); chk("R7 peek does not pop", d, 32'h100);
    for (int i = 0; i < 5; i++) begin
      rd(4'd7, d); chk($sformatf("R6 address %0d", i), d, exp_addr[i]);
      rd(4'd8, d); chk($sformatf("R6 length %0d", i), d, exp_len[i]);
    end
    rd(4'd1, d); chk("R7 drained", {28'd0, d[15:12]}, 32'd0);

    // R9: clear; input-low flag comes back because level 0 <= 4
    wr(4'd1, 32'd0);
    wait_cyc(2);
    rd(4'd1, d); chk("R9 clear then re-arm", d, 32'h1);
    chk("R9 irq low after clear", {31'd0, irq}, 32'd0);

    // R10: nine zero-length descriptors, completed FIFO holds eight
    for (int i = 0; i < 9; i++) begin
      wr(4'd6, 32'd0);
      wr(4'd5, 32'h1000 + i);
    end
    wait_cyc(10);
    rd(4'd1, d); chk("R10 stall at full", {24'd0, d[15:8]}, 32'h80);
    rd(4'd7, d); chk("R10 first out", d, 32'h1000);
    rd(4'd8, d); chk("R10 first length", d, 32'd0);
    wait_cyc(5);
    rd(4'd1, d); chk("R10 held entry enters", {28'd0, d[15:12]}, 32'd8);
    for (int i = 1; i < 9; i++) begin
      rd(4'd7, d); chk($sformatf("R10 order %0d", i), d, 32'h1000 + i);
      rd(4'd8, d);
    end

    // R3: overflow with channel disabled
    wr(4'd0, 32'd0);
    for (int i = 0; i < 9; i++) begin
      wr(4'd6, 32'd4);
      wr(4'd5, 32'h2000 + i);
    end
    rd(4'd1, d);
    chk("R3 level stays 8", {28'd0, d[11:8]}, 32'd8);
    chk("R3 overflow flag", {31'd0, d[2]}, 32'd1);
    wait_cyc(3);
    rd(4'd1, d); chk("R3 overflow sticky", {31'd0, d[2]}, 32'd1);
    wr(4'd1, 32'd0);
    rd(4'd1, d); chk("R3 overflow cleared", {31'd0, d[2]}, 32'd0);

    // R1: reset in mid-run
    @(negedge clk); rst_n = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(5);
    rd(4'd1, d); chk("R1 status after reset", d, 32'h1);
    rd(4'd4, d); chk("R1 threshold after reset", d, 32'h4);
    chk("R1 irq after second reset", {31'd0, irq}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule